// File: doc/BRIEF.md
# UART Register Front End with Prioritised Interrupt

This block is the software-facing half of a 16550-style serial port. A processor reaches it through a 32-bit, word-addressed register port holding eight registers. On one side it holds a single received byte together with its line status. On the other side it hands bytes written by software to a transmit stream. It keeps the interrupt-enable, line-control, modem-control and divisor settings. It folds the pending conditions into one level interrupt and a 3-bit identification code.

The serial shifters, the baud generator and the modem pin synchronisers sit outside the block. They exchange bytes through valid/ready pairs. They report parity, framing and break events and modem-line changes as single-cycle pulses, and they read the stored settings from dedicated outputs. A byte on the receive input is always captured, even while the ready output is low, because a shift register cannot be stalled. Such an arrival is recorded as an overrun.

Register word addresses: 0 data, 1 interrupt enable, 2 interrupt identification, 3 line control, 4 modem control, 5 line status, 6 modem status, 7 divisor. Read data is combinational during the access cycle. Read side effects take place at the clock edge that ends the access.

Top module: `uart_regbank`

## Requirements
- R1: After reset, line status reads 0x60, identification reads 0x01, `irq` is low, `rx_ready` is high, `tx_valid` is low, and all configuration outputs are zero.
- R2: A cycle with `rx_valid` high stores `rx_data` and sets line-status bit 0 (data ready). A read of address 0 returns the stored byte in bits 7:0 and clears bit 0. `rx_ready` is high exactly while bit 0 is clear.
- R3: An arrival while bit 0 is set, and not in the same cycle as a read of address 0, sets line-status bit 1 (overrun). The new byte replaces the old one and bit 0 stays set. An arrival in the same cycle as a read of address 0 leaves bit 1 unchanged.
- R4: Pulses on `err_parity`, `err_frame` and `err_break` set line-status bits 2, 3 and 4. A read of address 5 clears bits 1 to 4 after the access, except for a bit whose event arrives in that same cycle. Bits 31:7 read as zero.
- R5: Modem status reads `{modem_level, delta}`. Each `modem_delta` pulse sets its delta bit, and the bit stays set until a read of address 6 clears it. A pulse in the same cycle as that read wins.
- R6: Interrupt-enable bits: 0 receive, 1 transmit-empty, 2 line error, 3 modem. The identification register reads, highest priority first: 3'b110 for line bits 1 to 4 with enable 2; 3'b100 for data ready with enable 0; 3'b010 for line-status bit 5 with enable 1; 3'b000 for any delta bit with enable 3; otherwise 3'b001.
- R7: `irq` is high exactly when identification differs from 3'b001.
- R8: Addresses 1, 3, 4 and 7 read as zero. Writes there store bits 3:0 into the interrupt enable, and bits 7:0, bits 7:0 and bits DIV_W-1:0 onto `line_ctrl`, `modem_ctrl` and `baud_div`.
- R9: Writes to addresses 2, 5 and 6 change no state.
- R10: A write to address 0 while no byte is held drives `tx_valid` high with `tx_data` equal to write-data bits 7:0 in that same cycle.
- R11: If `tx_ready` is low during such a write, the byte is held and `tx_valid` stays high. Line-status bits 5 and 6 read zero until the cycle after the byte is accepted, and then read one. A write to address 0 while a byte is held is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_sel | input | 1 | Register access in this cycle |
| bus_wr | input | 1 | 1 write, 0 read |
| bus_addr | input | 3 | Word address |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data, valid during a read cycle, zero otherwise |
| rx_valid | input | 1 | Received byte present |
| rx_data | input | BYTE_W | Received byte |
| rx_ready | output | 1 | Holding register empty |
| tx_valid | output | 1 | Transmit byte offered |
| tx_data | output | BYTE_W | Transmit byte |
| tx_ready | input | 1 | Transmit stream takes the byte |
| err_parity | input | 1 | Parity error pulse |
| err_frame | input | 1 | Framing error pulse |
| err_break | input | 1 | Break pulse |
| modem_delta | input | 4 | Modem-line change pulses |
| modem_level | input | 4 | Current modem-line levels |
| line_ctrl | output | BYTE_W | Stored line control |
| modem_ctrl | output | BYTE_W | Stored modem control |
| baud_div | output | DIV_W | Stored divisor |
| irq | output | 1 | Level interrupt |

## Verification
The bench builds the block with a 32-bit bus, 8-bit bytes and a 12-bit divisor. Because the divisor is narrower than the bus, random divisor writes show whether the upper write-data bits are dropped. With the 8-bit byte width, the line- and modem-status fields sit at their fixed bit positions. Random traffic runs on a stalling transmit stream and on frequent receive and event pulses. This brings within reach the coincidences that matter here: an arrival during a data read, an error pulse during a status read, a modem pulse during a modem-status read, and a write during a held transmit byte.

// File: rtl/uart_regbank_pkg.sv
// Shared register indices, identification codes and enable bit positions.
package uart_regbank_pkg;
    timeunit 1ns;
    timeprecision 1ps;

    localparam int REG_AW  = 3;   // eight word registers
    localparam int ERR_N   = 3;   // parity, frame, break flags
    localparam int MDM_N   = 4;   // modem delta bits

    typedef enum logic [REG_AW-1:0] {
        RG_DATA  = 3'd0,
        RG_IEN   = 3'd1,
        RG_IID   = 3'd2,
        RG_LCTL  = 3'd3,
        RG_MCTL  = 3'd4,
        RG_LSTAT = 3'd5,
        RG_MSTAT = 3'd6,
        RG_BDIV  = 3'd7
    } reg_sel_e;

    localparam logic [2:0] IID_LINE  = 3'b110;
    localparam logic [2:0] IID_RXD   = 3'b100;
    localparam logic [2:0] IID_TXE   = 3'b010;
    localparam logic [2:0] IID_MODEM = 3'b000;
    localparam logic [2:0] IID_NONE  = 3'b001;

    localparam int EN_RXD   = 0;
    localparam int EN_TXE   = 1;
    localparam int EN_LINE  = 2;
    localparam int EN_MODEM = 3;
endpackage

// File: rtl/urb_rx_hold.sv
// Receive holding register and line flags.
// Holds one byte, the data-ready and overrun flags, and sticky error flags.
// Assumes error pulses are single-cycle; a set event wins over a clearing read.
module urb_rx_hold
    import uart_regbank_pkg::*;
#(
    parameter int BYTE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rx_valid,
    input  logic [BYTE_W-1:0] rx_data,
    input  logic              rd_data,
    input  logic              rd_lstat,
    input  logic [ERR_N-1:0]  err_in,
    output logic [BYTE_W-1:0] rx_byte,
    output logic              dr,
    output logic              oe,
    output logic [ERR_N-1:0]  err_q
);
    timeunit 1ns;
    timeprecision 1ps;

    // Capture the byte and track data ready and overrun.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rx_byte <= '0;
            dr      <= 1'b0;
            oe      <= 1'b0;
        end else begin
            if (rx_valid) begin
                rx_byte <= rx_data;
            end
            dr <= rx_valid | (dr & ~rd_data);
            oe <= (rx_valid & dr & ~rd_data) | (oe & ~rd_lstat);
        end
    end

    // One sticky flag per error source, cleared by a line-status read.
    for (genvar g = 0; g < ERR_N; g++) begin : g_err
        logic flag;
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                flag <= 1'b0;
            end else begin
                flag <= err_in[g] | (flag & ~rd_lstat);
            end
        end
        assign err_q[g] = flag;
    end
endmodule

// File: rtl/urb_msr_track.sv
// Sticky modem-change flags.
// Each bit is set by its pulse and cleared by a modem-status read; set wins.
module urb_msr_track
    import uart_regbank_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic [MDM_N-1:0] delta_in,
    input  logic             rd_mstat,
    output logic [MDM_N-1:0] delta_q
);
    timeunit 1ns;
    timeprecision 1ps;

    for (genvar g = 0; g < MDM_N; g++) begin : g_bit
        logic flag;
        // Hold one delta bit until it is read.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                flag <= 1'b0;
            end else begin
                flag <= delta_in[g] | (flag & ~rd_mstat);
            end
        end
        assign delta_q[g] = flag;
    end
endmodule

// File: rtl/urb_tx_hold.sv
// Transmit holding stage.
// A write passes straight to the stream when it is ready; otherwise the byte is
// held until accepted. Writes while a byte is held are dropped.
module urb_tx_hold #(
    parameter int BYTE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_byte,
    input  logic [BYTE_W-1:0] wr_data,
    input  logic              tx_ready,
    output logic              tx_valid,
    output logic [BYTE_W-1:0] tx_data,
    output logic              full
);
    timeunit 1ns;
    timeprecision 1ps;

    logic [BYTE_W-1:0] hold_q;
    logic              take;

    assign take = wr_byte & ~full;

    // Track whether a byte waits for the stream.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            full   <= 1'b0;
            hold_q <= '0;
        end else begin
            full <= full ? ~tx_ready : (take & ~tx_ready);
            if (take) begin
                hold_q <= wr_data;
            end
        end
    end

    // Offer the held byte, or the byte being written this cycle.
    always_comb begin
        tx_valid = full | wr_byte;
        tx_data  = full ? hold_q : wr_data;
    end
endmodule

// File: rtl/urb_irq_enc.sv
// Fixed-priority interrupt identification encoder.
// Purely combinational from state flops; no input-to-output bus path.
module urb_irq_enc
    import uart_regbank_pkg::*;
(
    input  logic [3:0]       ien,
    input  logic [3:0]       line_err,
    input  logic             dr,
    input  logic             thre,
    input  logic [MDM_N-1:0] delta,
    output logic [2:0]       iid
);
    timeunit 1ns;
    timeprecision 1ps;

    // Pick the highest pending enabled source.
    always_comb begin
        if (ien[EN_LINE] && (|line_err)) begin
            iid = IID_LINE;
        end else if (ien[EN_RXD] && dr) begin
            iid = IID_RXD;
        end else if (ien[EN_TXE] && thre) begin
            iid = IID_TXE;
        end else if (ien[EN_MODEM] && (|delta)) begin
            iid = IID_MODEM;
        end else begin
            iid = IID_NONE;
        end
    end
endmodule

// File: rtl/uart_regbank.sv
// UART register front end.
// Decodes word accesses, stores the configuration registers, builds read data
// and ties together receive holding, modem flags, transmit holding and the
// interrupt encoder. Assumes BYTE_W >= 8 and DATA_W >= DIV_W.
module uart_regbank
    import uart_regbank_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int BYTE_W = 8,
    parameter int DIV_W  = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [REG_AW-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic              rx_valid,
    input  logic [BYTE_W-1:0] rx_data,
    output logic              rx_ready,
    output logic              tx_valid,
    output logic [BYTE_W-1:0] tx_data,
    input  logic              tx_ready,
    input  logic              err_parity,
    input  logic              err_frame,
    input  logic              err_break,
    input  logic [MDM_N-1:0]  modem_delta,
    input  logic [MDM_N-1:0]  modem_level,
    output logic [BYTE_W-1:0] line_ctrl,
    output logic [BYTE_W-1:0] modem_ctrl,
    output logic [DIV_W-1:0]  baud_div,
    output logic              irq
);
    timeunit 1ns;
    timeprecision 1ps;

    localparam int LSR_W = 7;

    reg_sel_e          sel;
    logic              rd_en, wr_en;
    logic              rd_data, rd_lstat, rd_mstat, wr_byte;
    logic [3:0]        ier_q;
    logic [BYTE_W-1:0] lctl_q, mctl_q;
    logic [DIV_W-1:0]  bdiv_q;
    logic [BYTE_W-1:0] rx_byte;
    logic              st_dr, st_oe, tx_full, st_thre;
    logic [ERR_N-1:0]  err_q;
    logic [3:0]        line_err;
    logic [MDM_N-1:0]  msr_delta;
    logic [2:0]        iid;
    logic [LSR_W-1:0]  lsr;

    // Access decode.
    always_comb begin
        sel      = reg_sel_e'(bus_addr);
        rd_en    = bus_sel & ~bus_wr;
        wr_en    = bus_sel & bus_wr;
        rd_data  = rd_en & (sel == RG_DATA);
        rd_lstat = rd_en & (sel == RG_LSTAT);
        rd_mstat = rd_en & (sel == RG_MSTAT);
        wr_byte  = wr_en & (sel == RG_DATA);
    end

    // Configuration registers, write-only from the bus.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ier_q  <= '0;
            lctl_q <= '0;
            mctl_q <= '0;
            bdiv_q <= '0;
        end else if (wr_en) begin
            unique case (sel)
                RG_IEN:  ier_q  <= bus_wdata[3:0];
                RG_LCTL: lctl_q <= bus_wdata[BYTE_W-1:0];
                RG_MCTL: mctl_q <= bus_wdata[BYTE_W-1:0];
                RG_BDIV: bdiv_q <= bus_wdata[DIV_W-1:0];
                default: ;
            endcase
        end
    end

    urb_rx_hold #(.BYTE_W(BYTE_W)) u_rx (
        .clk      (clk),
        .rst_n    (rst_n),
        .rx_valid (rx_valid),
        .rx_data  (rx_data),
        .rd_data  (rd_data),
        .rd_lstat (rd_lstat),
        .err_in   ({err_break, err_frame, err_parity}),
        .rx_byte  (rx_byte),
        .dr       (st_dr),
        .oe       (st_oe),
        .err_q    (err_q)
    );

    urb_msr_track u_msr (
        .clk      (clk),
        .rst_n    (rst_n),
        .delta_in (modem_delta),
        .rd_mstat (rd_mstat),
        .delta_q  (msr_delta)
    );

    urb_tx_hold #(.BYTE_W(BYTE_W)) u_tx (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_byte  (wr_byte),
        .wr_data  (bus_wdata[BYTE_W-1:0]),
        .tx_ready (tx_ready),
        .tx_valid (tx_valid),
        .tx_data  (tx_data),
        .full     (tx_full)
    );

    // Line status assembly: bit0 ready, bit1 overrun, bits 4:2 errors, 6:5 empty.
    always_comb begin
        st_thre  = ~tx_full;
        line_err = {err_q, st_oe};
        lsr      = {st_thre, st_thre, err_q, st_oe, st_dr};
    end

    urb_irq_enc u_irq (
        .ien      (ier_q),
        .line_err (line_err),
        .dr       (st_dr),
        .thre     (st_thre),
        .delta    (msr_delta),
        .iid      (iid)
    );

    // Read data multiplexer; write-only and idle cycles return zero.
    always_comb begin
        bus_rdata = '0;
        if (rd_en) begin
            unique case (sel)
                RG_DATA:  bus_rdata[BYTE_W-1:0]    = rx_byte;
                RG_IID:   bus_rdata[2:0]           = iid;
                RG_LSTAT: bus_rdata[LSR_W-1:0]     = lsr;
                RG_MSTAT: bus_rdata[2*MDM_N-1:0]   = {modem_level, msr_delta};
                default:  ;
            endcase
        end
    end

    // Outputs to the neighbouring logic.
    always_comb begin
        rx_ready   = ~st_dr;
        line_ctrl  = lctl_q;
        modem_ctrl = mctl_q;
        baud_div   = bdiv_q;
        irq        = (iid != IID_NONE);
    end
endmodule

// File: rtl/uart_regbank_chk.sv
// Assertion checker for uart_regbank, attached by bind.
module uart_regbank_chk
    import uart_regbank_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int BYTE_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bus_sel,
    input logic              bus_wr,
    input logic [REG_AW-1:0] bus_addr,
    input logic [DATA_W-1:0] bus_rdata,
    input logic              rx_valid,
    input logic              rx_ready,
    input logic              tx_valid,
    input logic [BYTE_W-1:0] tx_data,
    input logic              tx_ready,
    input logic [MDM_N-1:0]  modem_delta,
    input logic              irq,
    input logic [3:0]        ier,
    input logic [3:0]        line_err,
    input logic              dr,
    input logic              thre,
    input logic [MDM_N-1:0]  msr_delta,
    input logic [2:0]        iid
);
    timeunit 1ns;
    timeprecision 1ps;

    p_reset_idle_r1: assert property (@(posedge clk)
        !rst_n |=> (rx_ready && !tx_valid && !irq));

    p_byte_blocks_ready_r2: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid |=> !rx_ready);

    p_overrun_set_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_valid && dr && !(bus_sel && !bus_wr && bus_addr == 3'd0)) |=> line_err[0]);

    p_msr_cleared_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_sel && !bus_wr && bus_addr == 3'd6 && modem_delta == '0) |=> (msr_delta == '0));

    p_line_first_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (ier[EN_LINE] && (|line_err)) |-> (iid == IID_LINE));

    p_rx_second_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!(ier[EN_LINE] && (|line_err)) && ier[EN_RXD] && dr) |-> (iid == IID_RXD));

    p_tx_third_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!(|line_err) && !dr && ier[EN_TXE] && thre) |-> (iid == IID_TXE));

    p_irq_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (ier == 4'd0) |-> !irq);

    p_wo_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_sel && !bus_wr && (bus_addr == 3'd1 || bus_addr == 3'd3 ||
         bus_addr == 3'd4 || bus_addr == 3'd7)) |-> (bus_rdata == '0));

    p_tx_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_valid && !tx_ready) |=> (tx_valid && $stable(tx_data) && !thre));
endmodule

bind uart_regbank uart_regbank_chk #(.DATA_W(DATA_W), .BYTE_W(BYTE_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .bus_sel     (bus_sel),
    .bus_wr      (bus_wr),
    .bus_addr    (bus_addr),
    .bus_rdata   (bus_rdata),
    .rx_valid    (rx_valid),
    .rx_ready    (rx_ready),
    .tx_valid    (tx_valid),
    .tx_data     (tx_data),
    .tx_ready    (tx_ready),
    .modem_delta (modem_delta),
    .irq         (irq),
    .ier         (ier_q),
    .line_err    (line_err),
    .dr          (st_dr),
    .thre        (st_thre),
    .msr_delta   (msr_delta),
    .iid         (iid)
);

// File: tb/uart_regbank_tb.sv
// Self-checking bench: directed corner cases, then seeded random traffic,
// compared every cycle against a bench-side model of the requirements.
module uart_regbank_tb;
    timeunit 1ns;
    timeprecision 1ps;

    localparam int DATA_W = 32;
    localparam int BYTE_W = 8;
    localparam int DIV_W  = 12;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              sel, wr;
    logic [2:0]        addr;
    logic [DATA_W-1:0] wdata;
    logic [DATA_W-1:0] rdata;
    logic              rxv;
    logic [BYTE_W-1:0] rxd;
    logic              rx_ready, tx_valid, txr, irq;
    logic [BYTE_W-1:0] tx_data, line_ctrl, modem_ctrl;
    logic [DIV_W-1:0]  baud_div;
    logic              ep, ef, eb;
    logic [3:0]        md, ml;

    int tests = 0;
    int fails = 0;
    bit done  = 0;

    // Model state.
    logic [7:0]       m_rx, m_tbuf, m_lctl, m_mctl;
    logic [DIV_W-1:0] m_bdiv;
    logic [3:0]       m_ier, m_dmsr;
    logic             m_dr, m_oe, m_pe, m_fe, m_bi, m_full;

    always #2 clk = ~clk;

    uart_regbank #(.DATA_W(DATA_W), .BYTE_W(BYTE_W), .DIV_W(DIV_W)) u_dut (
        .clk(clk), .rst_n(rst_n), .bus_sel(sel), .bus_wr(wr), .bus_addr(addr),
        .bus_wdata(wdata), .bus_rdata(rdata), .rx_valid(rxv), .rx_data(rxd),
        .rx_ready(rx_ready), .tx_valid(tx_valid), .tx_data(tx_data), .tx_ready(txr),
        .err_parity(ep), .err_frame(ef), .err_break(eb), .modem_delta(md),
        .modem_level(ml), .line_ctrl(line_ctrl), .modem_ctrl(modem_ctrl),
        .baud_div(baud_div), .irq(irq)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic logic [6:0] m_lsr();
        return {~m_full, ~m_full, m_bi, m_fe, m_pe, m_oe, m_dr};
    endfunction

    function automatic logic [2:0] m_iid();
        if (m_ier[2] && (m_oe | m_pe | m_fe | m_bi)) return 3'b110;
        if (m_ier[0] && m_dr)                        return 3'b100;
        if (m_ier[1] && !m_full)                     return 3'b010;
        if (m_ier[3] && (|m_dmsr))                   return 3'b000;
        return 3'b001;
    endfunction

    task automatic model_reset();
        m_rx = '0; m_tbuf = '0; m_lctl = '0; m_mctl = '0; m_bdiv = '0;
        m_ier = '0; m_dmsr = '0;
        m_dr = 0; m_oe = 0; m_pe = 0; m_fe = 0; m_bi = 0; m_full = 0;
    endtask

    task automatic idle();
        sel = 0; wr = 0; addr = '0; wdata = '0; rxv = 0; rxd = '0;
        ep = 0; ef = 0; eb = 0; md = '0; ml = '0; txr = 1;
    endtask

    task automatic check_outputs();
        logic [6:0] el;
        el = m_lsr();
        if (sel && !wr) begin
            case (addr)
                3'd0: chk("R2 data read", rdata, {24'b0, m_rx});
                3'd2: chk("R6 identification", rdata, {29'b0, m_iid()});
                3'd5: begin
                    chk("R2 ready bit", {31'b0, rdata[0]}, {31'b0, el[0]});
                    chk("R3 overrun bit", {31'b0, rdata[1]}, {31'b0, el[1]});
                    chk("R4 error bits", {rdata[31:7], rdata[4:2]}, {25'b0, el[4:2]});
                    chk("R11 empty bits", {30'b0, rdata[6:5]}, {30'b0, el[6:5]});
                end
                3'd6: chk("R5 modem status", rdata, {24'b0, ml, m_dmsr});
                default: chk("R8 write-only reads zero", rdata, 32'd0);
            endcase
        end else begin
            chk("R8 idle read data", rdata, 32'd0);
        end
        chk("R2 rx_ready", {31'b0, rx_ready}, {31'b0, ~m_dr});
        chk("R10 tx_valid", {31'b0, tx_valid}, {31'b0, m_full | (sel & wr & (addr == 3'd0))});
        if (m_full)
            chk("R11 held tx_data", {24'b0, tx_data}, {24'b0, m_tbuf});
        else if (sel && wr && addr == 3'd0)
            chk("R10 pass tx_data", {24'b0, tx_data}, {24'b0, wdata[7:0]});
        chk("R7 irq", {31'b0, irq}, {31'b0, m_iid() != 3'b001});
        chk("R8 config outputs", {line_ctrl, modem_ctrl, 4'b0, baud_div},
            {m_lctl, m_mctl, 4'b0, m_bdiv});
    endtask

    task automatic model_update();
        logic rd0, rd5, rd6, wr0, odr;
        rd0 = sel & ~wr & (addr == 3'd0);
        rd5 = sel & ~wr & (addr == 3'd5);
        rd6 = sel & ~wr & (addr == 3'd6);
        wr0 = sel & wr & (addr == 3'd0);
        odr = m_dr;
        if (rxv) m_rx = rxd;
        m_dr  = rxv | (odr & ~rd0);
        m_oe  = (rxv & odr & ~rd0) | (m_oe & ~rd5);
        m_pe  = ep | (m_pe & ~rd5);
        m_fe  = ef | (m_fe & ~rd5);
        m_bi  = eb | (m_bi & ~rd5);
        m_dmsr = md | (m_dmsr & {4{~rd6}});
        if (sel && wr) begin
            case (addr)
                3'd1: m_ier  = wdata[3:0];
                3'd3: m_lctl = wdata[7:0];
                3'd4: m_mctl = wdata[7:0];
                3'd7: m_bdiv = wdata[DIV_W-1:0];
                default: ;
            endcase
        end
        if (m_full) begin
            m_full = ~txr;
        end else begin
            if (wr0) m_tbuf = wdata[7:0];
            m_full = wr0 & ~txr;
        end
    endtask

    // One bus cycle: inputs already set after a falling edge.
    task automatic step();
        #1;
        check_outputs();
        @(posedge clk);
        model_update();
        @(negedge clk);
    endtask

    task automatic acc(input logic w, input logic [2:0] a, input logic [31:0] d);
        idle();
        sel = 1; wr = w; addr = a; wdata = d;
    endtask

    function automatic string summary();
        return $sformatf("[TB] %0d tests run, %0d failed", tests, fails);
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            tests++; fails++;
            $display("FAIL watchdog (all requirements): actual hung expected finished");
            $display("%s", summary());
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd2718));
        idle();
        model_reset();
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1;

        // R1: reset state observed through the ports.
        acc(0, 3'd5, 0);
        #0.5;
        chk("R1 line status after reset", rdata, 32'h60);
        chk("R1 irq low", {31'b0, irq}, 32'd0);
        chk("R1 rx_ready high", {31'b0, rx_ready}, 32'd1);
        chk("R1 tx_valid low", {31'b0, tx_valid}, 32'd0);
        chk("R1 config zero", {line_ctrl, modem_ctrl, 4'b0, baud_div}, 32'd0);
        addr = 3'd2;
        #0.5;
        chk("R1 identification after reset", rdata, 32'h1);
        step();

        // R2, R6: receive with only the receive enable.
        acc(1, 3'd1, 32'h1); step();
        idle(); rxv = 1; rxd = 8'h5A; step();
        acc(0, 3'd2, 0); step();
        acc(0, 3'd0, 0); step();
        acc(0, 3'd5, 0); step();
        // R3: overrun, then arrival coinciding with a data read.
        idle(); rxv = 1; rxd = 8'h11; step();
        idle(); rxv = 1; rxd = 8'h22; step();
        acc(0, 3'd5, 0); step();
        acc(0, 3'd0, 0); step();
        idle(); rxv = 1; rxd = 8'h33; step();
        acc(0, 3'd0, 0); rxv = 1; rxd = 8'h44; step();
        acc(0, 3'd5, 0); step();
        acc(0, 3'd0, 0); step();
        // R4: error pulse during a status read survives one read.
        acc(1, 3'd1, 32'h4); step();
        acc(0, 3'd5, 0); ep = 1; step();
        acc(0, 3'd5, 0); step();
        acc(0, 3'd5, 0); step();
        idle(); ef = 1; eb = 1; step();
        acc(0, 3'd2, 0); step();
        acc(0, 3'd5, 0); step();
        // R9: writes to read-only registers.
        acc(1, 3'd5, 32'hFFFF_FFFF); step();
        acc(1, 3'd2, 32'hFFFF_FFFF); step();
        acc(1, 3'd6, 32'hFFFF_FFFF); step();
        acc(0, 3'd5, 0);
        #0.5;
        chk("R9 line status unchanged", rdata, {25'b0, m_lsr()});
        step();
        acc(0, 3'd6, 0); ml = 4'h9;
        #0.5;
        chk("R9 modem status unchanged", rdata, {24'b0, 4'h9, m_dmsr});
        step();
        // R5: modem deltas and the modem-level interrupt.
        idle(); md = 4'b0101; step();
        acc(1, 3'd1, 32'h8); step();
        acc(0, 3'd2, 0); step();
        acc(0, 3'd6, 0); md = 4'b1000; step();
        acc(0, 3'd6, 0); step();
        acc(0, 3'd6, 0); step();
        // R10, R11: transmit pass-through, stall, dropped write, release.
        acc(1, 3'd1, 32'h2); step();
        acc(1, 3'd0, 32'h77); step();
        acc(1, 3'd0, 32'hA5); txr = 0; step();
        acc(0, 3'd5, 0); txr = 0; step();
        acc(1, 3'd0, 32'h3C); txr = 0; step();
        acc(0, 3'd2, 0); txr = 1; step();
        acc(0, 3'd5, 0); step();
        // R8: configuration writes and write-only reads.
        acc(1, 3'd3, 32'hDEAD_BE1B); step();
        acc(1, 3'd4, 32'h0000_0003); step();
        acc(1, 3'd7, 32'h1234_5678); step();
        for (int a = 0; a < 8; a++) begin
            acc(0, 3'(a), 0); step();
        end

        // Seeded random traffic.
        for (int i = 0; i < 4000; i++) begin
            sel   = ($urandom % 2) == 0;
            wr    = ($urandom % 3) == 0;
            addr  = 3'($urandom % 8);
            wdata = $urandom;
            rxv   = ($urandom % 5) == 0;
            rxd   = 8'($urandom);
            ep    = ($urandom % 12) == 0;
            ef    = ($urandom % 12) == 0;
            eb    = ($urandom % 15) == 0;
            md    = (($urandom % 6) == 0) ? 4'($urandom) : 4'd0;
            ml    = 4'($urandom);
            txr   = ($urandom % 3) != 0;
            step();
        end

        done = 1;
        $display("%s", summary());
        $finish;
    end
endmodule